// File: doc/BRIEF.md
# General-Purpose Event Register Block

This block holds a small bank of general-purpose event bytes for a power-management subsystem. It sits on a byte-wide I/O bus and decodes a window of `BLK_LEN` bytes that starts at a base address set by a port. The lower half of the window holds status bytes and the upper half holds enable bytes. Hardware event inputs set status bits. Software clears a status bit by writing a one to it. Enable bytes are plain read/write storage.

The block drives a level interrupt, `sci_o`. It rises when an enabled status bit that the `SCI_MASK` parameter selects is pending. By default only bit 1 of status byte 0 is selected, which is the device hotplug event. A second interrupt source from elsewhere in the power-management logic, `pm_other_i`, is ORed into the same line. The interrupt is held in a register, so it follows any change in status, enable or the other source one clock later.

Top module: `gpe_block`

## Requirements
- R1: After reset, every status byte and every enable byte reads 0x00 and `sci_o` is low.
- R2: The window offset is `(io_addr - blk_base)` modulo 2^16. Offsets 0 to `BLK_LEN/2-1` select status byte k at offset k, and offsets `BLK_LEN/2` to `BLK_LEN-1` select enable byte k at offset `BLK_LEN/2+k`. With the defaults there are 2 status bytes at offsets 0 and 1, and 2 enable bytes at offsets 2 and 3.
- R3: A write to a status byte clears each bit that is 1 in `io_wdata` and leaves every other bit of that byte unchanged.
- R4: A write to an enable byte replaces that byte with `io_wdata`.
- R5: `io_rdata` is combinational. While `io_rd` is high and the offset is inside the window, it shows the addressed byte. At all other times it is 0x00.
- R6: A write whose offset lies outside the window changes no status byte and no enable byte.
- R7: Bit j of `evt_i` sets bit j%8 of status byte j/8 at the next clock edge. Other bits of that byte are not changed by this input.
- R8: If an event sets a status bit in the same cycle that a write tries to clear it, the bit ends up set.
- R9: `sci_o` is high in the cycle after the clock edge where `(status & enable & SCI_MASK)` is nonzero or `pm_other_i` is high. Otherwise it is low. By default `SCI_MASK` selects bit 1 of byte 0 only.
- R10: When `blk_base` changes, the window moves with it. The old addresses stop reaching the block and the new ones start reaching it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_base | input | ADDR_W | Base I/O address of the window |
| io_addr | input | ADDR_W | Bus byte address |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| evt_i | input | 4*BLK_LEN | Hardware event set pulses, one per status bit |
| pm_other_i | input | 1 | Other power-management interrupt source |
| sci_o | output | 1 | Registered interrupt level |

## Verification
In a single cycle, a hardware event can set a status bit while a write-one-to-clear hits the same byte. That byte's next value then depends on both inputs at once. The bench provokes this in two ways. Directed cycles pulse an event on a bit that is being cleared, and on a neighbouring bit. A long pseudo-random phase also lets events and status writes overlap freely. A behavioural reference model in the bench, where the set always wins, judges every read and the interrupt level on every cycle.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

  typedef logic [7:0] gbyte_t;

  // next value of a status byte: clear the written ones, then OR the events in
  function automatic gbyte_t sts_next(input gbyte_t cur, input gbyte_t clr, input gbyte_t set);
    return (cur & ~clr) | set;
  endfunction

  // one byte's share of the interrupt: enabled, selected, pending bits
  function automatic logic pend_any(input gbyte_t sts, input gbyte_t en, input gbyte_t msk);
    return |(sts & en & msk);
  endfunction

endpackage

// File: rtl/gpe_decode.sv
module gpe_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BLK_LEN = 4,
  localparam int unsigned HALF   = BLK_LEN / 2,
  localparam int unsigned OFF_W  = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1
) (
  input  logic [ADDR_W-1:0] blk_base,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  output logic              in_range,
  output logic [OFF_W-1:0]  sel_off,
  output logic [HALF-1:0]   sts_wr,
  output logic [HALF-1:0]   en_wr
);

  logic [ADDR_W-1:0] off;

  assign off      = io_addr - blk_base;
  assign in_range = off < ADDR_W'(BLK_LEN);
  assign sel_off  = off[OFF_W-1:0];

  for (genvar i = 0; i < HALF; i++) begin : g_sel
    assign sts_wr[i] = io_wr && (off == ADDR_W'(i));
    assign en_wr[i]  = io_wr && (off == ADDR_W'(HALF + i));
  end

endmodule

// File: rtl/gpe_sts_byte.sv
module gpe_sts_byte
  import gpe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_i,
  input  gbyte_t wdata_i,
  input  gbyte_t set_i,
  output gbyte_t q_o
);

  gbyte_t clr;

  assign clr = wr_i ? wdata_i : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 8'h00;
    else        q_o <= sts_next(q_o, clr, set_i);
  end

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && set_i == 8'h00) |=> (q_o == ($past(q_o) & ~$past(wdata_i))));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != 8'h00) |=> ((q_o & $past(set_i)) == $past(set_i)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && set_i == 8'h00) |=> $stable(q_o));

endmodule

// File: rtl/gpe_en_byte.sv
module gpe_en_byte
  import gpe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_i,
  input  gbyte_t wdata_i,
  output gbyte_t q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 8'h00;
    else if (wr_i) q_o <= wdata_i;
  end

  assert_en_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (q_o == $past(wdata_i)));

  assert_en_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(q_o));

endmodule

// File: rtl/gpe_sci.sv
module gpe_sci
  import gpe_pkg::*;
#(
  parameter int unsigned HALF = 2,
  parameter logic [HALF*8-1:0] SCI_MASK = 16'h0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF*8-1:0] sts_i,
  input  logic [HALF*8-1:0] en_i,
  input  logic              other_i,
  output logic              sci_o
);

  logic [HALF-1:0] pend;
  logic            lvl;

  for (genvar k = 0; k < HALF; k++) begin : g_pend
    assign pend[k] = pend_any(sts_i[k*8 +: 8], en_i[k*8 +: 8], SCI_MASK[k*8 +: 8]);
  end

  assign lvl = (|pend) || other_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sci_o <= 1'b0;
    else        sci_o <= lvl;
  end

  assert_sci_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((sts_i & en_i & SCI_MASK) != '0) || other_i) |=> sci_o);

  assert_sci_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((sts_i & en_i & SCI_MASK) == '0) && !other_i) |=> !sci_o);

endmodule

// File: rtl/gpe_block.sv
module gpe_block
  import gpe_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BLK_LEN = 4,
  parameter logic [BLK_LEN*4-1:0] SCI_MASK = 'h2,
  localparam int unsigned HALF  = BLK_LEN / 2,
  localparam int unsigned NBITS = HALF * 8,
  localparam int unsigned OFF_W = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] blk_base,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [NBITS-1:0]  evt_i,
  input  logic              pm_other_i,
  output logic              sci_o
);

  logic             in_range;
  logic [OFF_W-1:0] sel_off;
  logic [HALF-1:0]  sts_wr;
  logic [HALF-1:0]  en_wr;
  logic [NBITS-1:0] sts_vec;
  logic [NBITS-1:0] en_vec;

  gpe_decode #(.ADDR_W(ADDR_W), .BLK_LEN(BLK_LEN)) u_dec (
    .blk_base (blk_base),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .in_range (in_range),
    .sel_off  (sel_off),
    .sts_wr   (sts_wr),
    .en_wr    (en_wr)
  );

  for (genvar k = 0; k < HALF; k++) begin : g_bank
    gpe_sts_byte u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (sts_wr[k]),
      .wdata_i (io_wdata),
      .set_i   (evt_i[k*8 +: 8]),
      .q_o     (sts_vec[k*8 +: 8])
    );
    gpe_en_byte u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (en_wr[k]),
      .wdata_i (io_wdata),
      .q_o     (en_vec[k*8 +: 8])
    );
  end

  gpe_sci #(.HALF(HALF), .SCI_MASK(SCI_MASK)) u_sci (
    .clk     (clk),
    .rst_n   (rst_n),
    .sts_i   (sts_vec),
    .en_i    (en_vec),
    .other_i (pm_other_i),
    .sci_o   (sci_o)
  );

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && in_range) begin
      for (int k = 0; k < HALF; k++) begin
        if (sel_off == OFF_W'(k))        io_rdata = sts_vec[k*8 +: 8];
        if (sel_off == OFF_W'(HALF + k)) io_rdata = en_vec[k*8 +: 8];
      end
    end
  end

  assert_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sts_wr, en_wr}));

  assert_outside_nowr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> ({sts_wr, en_wr} == '0));

  assert_rd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd || !in_range) |-> (io_rdata == 8'h00));

endmodule

// File: tb/sim_gpe_block.sv
`timescale 1ns/1ps
module sim_gpe_block;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] blk_base = 16'hAFE0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [15:0] evt_i = '0;
  logic        pm_other_i = 1'b0;
  logic        sci_o;

  int total = 0;
  int bad = 0;

  logic [7:0] m_sts [2];
  logic [7:0] m_en  [2];
  logic       m_sci;

  always #2 clk = ~clk;

  gpe_block u0 (
    .clk(clk), .rst_n(rst_n), .blk_base(blk_base), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .evt_i(evt_i), .pm_other_i(pm_other_i), .sci_o(sci_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [15:0] a);
    logic [15:0] off;
    off = a - blk_base;
    if (off == 16'd0) return m_sts[0];
    if (off == 16'd1) return m_sts[1];
    if (off == 16'd2) return m_en[0];
    if (off == 16'd3) return m_en[1];
    return 8'h00;
  endfunction

  // one bus cycle: drive at the falling edge, check, then advance the model
  task automatic step(input logic [15:0] a, input logic wr, input logic rd,
                      input logic [7:0] wd, input logic [15:0] ev,
                      input logic oth, input string tag);
    logic [15:0] off;
    logic        nsci;
    logic [7:0]  clr;
    @(negedge clk);
    io_addr = a; io_wr = wr; io_rd = rd; io_wdata = wd; evt_i = ev; pm_other_i = oth;
    #1;
    chk({7'd0, sci_o}, {7'd0, m_sci}, "R9");
    chk(io_rdata, rd ? model_read(a) : 8'h00, tag);
    nsci = ((m_sts[0] & m_en[0] & 8'h02) != 8'h00) || oth;
    off = a - blk_base;
    for (int k = 0; k < 2; k++) begin
      clr = (wr && off == 16'(k)) ? wd : 8'h00;
      m_sts[k] = (m_sts[k] & ~clr) | ev[k*8 +: 8];
      if (wr && off == 16'(2 + k)) m_en[k] = wd;
    end
    m_sci = nsci;
    @(posedge clk);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] b;
    m_sts[0] = 0; m_sts[1] = 0; m_en[0] = 0; m_en[1] = 0; m_sci = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    b = 16'hAFE0;
    // R1: reset state
    for (int i = 0; i < 4; i++) step(b + 16'(i), 0, 1, 8'h00, 16'h0000, 0, "R1");
    // R4: enable writes and read back
    step(b + 2, 1, 0, 8'hFF, 16'h0, 0, "R4");
    step(b + 3, 1, 0, 8'h5A, 16'h0, 0, "R4");
    step(b + 2, 0, 1, 8'h00, 16'h0, 0, "R4");
    step(b + 3, 0, 1, 8'h00, 16'h0, 0, "R4");
    // R7 then R9: event bit 1 of byte 0 raises the interrupt
    step(b, 0, 0, 8'h00, 16'h0002, 0, "R7");
    step(b, 0, 1, 8'h00, 16'h0000, 0, "R7");
    step(b, 0, 1, 8'h00, 16'h0000, 0, "R9");
    // R3: write one to clear, interrupt falls
    step(b, 1, 0, 8'h02, 16'h0, 0, "R3");
    step(b, 0, 1, 8'h00, 16'h0, 0, "R3");
    step(b, 0, 1, 8'h00, 16'h0, 0, "R9");
    step(b, 0, 0, 8'h00, 16'h81F3, 0, "R7");
    step(b + 1, 0, 1, 8'h00, 16'h0, 0, "R7");
    step(b, 1, 0, 8'h30, 16'h0, 0, "R3");
    step(b, 0, 1, 8'h00, 16'h0, 0, "R3");
    // R8: set and clear collide on bit 0; bit 4 set while bit 7 cleared
    step(b, 1, 0, 8'h81, 16'h0011, 0, "R8");
    step(b, 0, 1, 8'h00, 16'h0, 0, "R8");
    // R6 / R5: writes and reads outside the window
    step(b + 4, 1, 0, 8'hFF, 16'h0, 0, "R6");
    step(b - 1, 1, 0, 8'hFF, 16'h0, 0, "R6");
    step(b + 4, 0, 1, 8'h00, 16'h0, 0, "R5");
    step(b - 1, 0, 1, 8'h00, 16'h0, 0, "R5");
    for (int i = 0; i < 4; i++) step(b + 16'(i), 0, 1, 8'h00, 16'h0, 0, "R6");
    // R9: the other source alone
    step(b, 1, 0, 8'hFF, 16'h0, 0, "R3");
    step(b, 0, 0, 8'h00, 16'h0, 1, "R9");
    step(b, 0, 0, 8'h00, 16'h0, 0, "R9");
    step(b, 0, 0, 8'h00, 16'h0, 0, "R9");
    // R10: move the window
    @(negedge clk); blk_base = 16'h1000; b = 16'h1000;
    step(16'hAFE2, 1, 0, 8'h00, 16'h0, 0, "R10");
    step(b + 2, 0, 1, 8'h00, 16'h0, 0, "R10");
    step(b + 2, 1, 0, 8'h3C, 16'h0, 0, "R10");
    step(b + 2, 0, 1, 8'h00, 16'h0, 0, "R10");
    step(16'hAFE2, 0, 1, 8'h00, 16'h0, 0, "R10");
    // R2: mixed pseudo-random traffic around the window
    r = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      step(b - 2 + 16'(r[2:0]), r[3], r[4], r[15:8],
           (r[7:5] == 3'd0) ? r[31:16] : 16'h0, r[20] & r[21], "R2");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule